// File: doc/BRIEF.md
# Shared Mailbox Bank with Interrupt Aggregation

This block holds a bank of single-slot 32-bit mailboxes through which two processors hand each other messages. The top bit of every slot word is its occupancy flag. A producer therefore loads a message and marks the slot occupied with one register write. The consumer releases the slot by writing the whole word back to zero. A hardware consumer can instead pulse a per-slot clear input.

Each slot drives two level conditions: "occupied" and "vacant". Each condition passes through that slot's own enable bit. The gated conditions are merged into one status word: vacant conditions sit in bits 7:0 and occupied conditions in bits 15:8. Every shared interrupt line has its own mask register with the same layout as the status word. A line is high while the status word AND its mask is non-zero.

A read-only capability word reports how many of each resource the instance has. Accesses go through a simple request port. Every request is acknowledged one cycle later, and read data arrives with that acknowledge.

Top module: `mbx_bank`

## Requirements
- R1: After reset every slot word, every enable bit and every line mask is zero, all interrupt lines are low, and `reg_ready` and `reg_rdata` are zero.
- R2: A write to slot n's data word (address 0x010*n) stores all 32 bits. Bit 31 is the occupancy flag and bits 30:0 are the payload. A read of that address returns the stored word.
- R3: Writing zero to a slot's data word clears both the occupancy flag and the payload.
- R4: A high `slot_clear[n]` zeroes slot n's data word at the next edge. If the port writes slot n's data word in the same cycle, the port write takes effect instead.
- R5: Status word (address 0x300) bit n is 1 exactly when slot n is vacant and its vacant-enable is set. Bit 8+n is 1 exactly when slot n is occupied and its occupied-enable is set. The bits stay at these levels for as long as the condition holds.
- R6: Line k's mask lives at 0x200+4*k. It stores only the status bit positions of implemented slots and reads back with every other bit zero. `irq_line[k]` is high exactly while status AND mask is non-zero.
- R7: The capability word at 0x310 is read-only. It carries 4-bit counts: slots in 3:0, shared semaphores in 7:4, arbitrated semaphores in 11:8, doorbells in 15:12 and interrupt lines in 19:16. All other bits are zero.
- R8: Unmapped addresses read as zero and writes to them change nothing. Unmapped addresses include slot offsets other than 0x0/0x4/0x8, slots at or above the slot count, and lines at or above the line count. Writes to the status and capability addresses are ignored.
- R9: `reg_ready` is high exactly one cycle after `reg_req`. For a read, `reg_rdata` holds the addressed value as it stood in the request cycle. For a write, `reg_rdata` is zero. Reading the status word changes no state.
- R10: The occupied-enable (slot offset 0x4) and vacant-enable (slot offset 0x8) registers hold only bit 0 of the written data and read back with bits 31:1 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_ready |
| reg_ready | output | 1 | Acknowledge, one cycle after reg_req |
| slot_clear | input | NUM_SLOTS | Hardware consumer release, one bit per slot |
| irq_line | output | NUM_LINES | Level interrupt outputs |

## Verification
The bench builds the bank with six slots, three interrupt lines and distinct semaphore and doorbell counts. These values make the slot 6 and 7 addresses, line 3 and above, and the unused status bit positions reachable as unmapped space. They also give every capability field a different non-zero value, so a misplaced field shows up. A reference model tracks each slot, enable and mask and predicts the read data, acknowledge and every interrupt line on every clock. A random stream then mixes port writes, clear pulses and reads across mapped and unmapped addresses on top of the directed cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int MAX_SLOTS = 8;
  localparam int MAX_LINES = 16;
  localparam int FLAG_BIT  = 31;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h300;
  localparam logic [ADDR_W-1:0] CAPS_ADDR   = 12'h310;

  typedef enum logic [2:0] {
    K_NONE,
    K_SLOT_DATA,
    K_SLOT_FEN,
    K_SLOT_EEN,
    K_LINE_MASK,
    K_STATUS,
    K_CAPS
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // Full address decode; anything not matched is K_NONE.
  function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int n_slots, int n_lines);
    reg_sel_t s;
    s.kind = K_NONE;
    s.idx  = '0;
    if (a[11:7] == 5'd0 && 32'(a[6:4]) < n_slots) begin
      s.idx = {1'b0, a[6:4]};
      case (a[3:0])
        4'h0:    s.kind = K_SLOT_DATA;
        4'h4:    s.kind = K_SLOT_FEN;
        4'h8:    s.kind = K_SLOT_EEN;
        default: s.kind = K_NONE;
      endcase
    end else if (a[11:6] == 6'b001000 && a[1:0] == 2'b00 && 32'(a[5:2]) < n_lines) begin
      s.kind = K_LINE_MASK;
      s.idx  = a[5:2];
    end else if (a == STATUS_ADDR) begin
      s.kind = K_STATUS;
    end else if (a == CAPS_ADDR) begin
      s.kind = K_CAPS;
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic [MAX_SLOTS-1:0] vacant,
                                                     logic [MAX_SLOTS-1:0] occupied);
    return {16'b0, occupied, vacant};
  endfunction

  function automatic logic [DATA_W-1:0] pack_caps(logic [3:0] n_mb, logic [3:0] n_ss,
                                                   logic [3:0] n_as, logic [3:0] n_db,
                                                   logic [3:0] n_ln);
    return {12'b0, n_ln, n_db, n_as, n_ss, n_mb};
  endfunction

  function automatic logic [15:0] status_valid(int n_slots);
    logic [7:0] ones;
    ones = 8'((1 << n_slots) - 1);
    return {ones, ones};
  endfunction

  function automatic logic line_hit(logic [15:0] status, logic [15:0] mask);
    return |(status & mask);
  endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_i,
  input  logic              wr_fen_i,
  input  logic              wr_een_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_clear_i,
  output logic [DATA_W-1:0] word_o,
  output logic              full_en_o,
  output logic              empty_en_o,
  output logic              occupied_o,
  output logic              vacant_o
);

  logic [DATA_W-1:0] word_q;
  logic              fen_q;
  logic              een_q;

  // Port write has priority over the hardware release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_data_i) begin
      word_q <= wdata_i;
    end else if (hw_clear_i) begin
      word_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= 1'b0;
      een_q <= 1'b0;
    end else begin
      if (wr_fen_i) fen_q <= wdata_i[0];
      if (wr_een_i) een_q <= wdata_i[0];
    end
  end

  assign word_o     = word_q;
  assign full_en_o  = fen_q;
  assign empty_en_o = een_q;
  assign occupied_o = word_q[FLAG_BIT] & fen_q;
  assign vacant_o   = ~word_q[FLAG_BIT] & een_q;

  // R2: a port write lands verbatim
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_i |=> word_o == $past(wdata_i));

  // R4: hardware release empties the slot unless the port writes it
  p_hw_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clear_i && !wr_data_i) |=> word_o == '0);

  // R5: the occupied condition is a level that persists while nothing touches the slot
  p_occupied_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occupied_o && !wr_data_i && !hw_clear_i && !wr_fen_i) |=> occupied_o);

  // R5: the vacant condition persists likewise
  p_vacant_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vacant_o && !wr_data_i && !wr_een_i) |=> vacant_o);

endmodule

// File: rtl/mbx_line.sv
module mbx_line
  import mbx_pkg::*;
#(
  parameter logic [15:0] VALID = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] status_i,
  output logic [15:0] mask_o,
  output logic        irq_o
);

  logic [15:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q <= wdata_i & VALID;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = line_hit(status_i, mask_q);

  // R6: mask stores only implemented positions
  p_mask_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> mask_o == ($past(wdata_i) & VALID));

  // R6: a line never fires with an empty mask or a quiet status word
  p_irq_needs_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_o != '0 && status_i != '0));

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_SLOTS      = 8,
  parameter int NUM_LINES      = 4,
  parameter int SEM_SHARED_CNT = 0,
  parameter int SEM_ARB_CNT    = 0,
  parameter int DOORBELL_CNT   = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_ready,
  input  logic [NUM_SLOTS-1:0] slot_clear,
  output logic [NUM_LINES-1:0] irq_line
);

  localparam logic [15:0] VALID16 = status_valid(NUM_SLOTS);
  localparam logic [31:0] CAPS_WORD = pack_caps(4'(NUM_SLOTS), 4'(SEM_SHARED_CNT),
                                                4'(SEM_ARB_CNT), 4'(DOORBELL_CNT),
                                                4'(NUM_LINES));

  // Named events for the checks below
  reg_sel_t    sel;
  logic        wr_go;
  logic        rd_go;
  logic        unmapped_wr;

  logic [DATA_W-1:0]    slot_word [MAX_SLOTS];
  logic [MAX_SLOTS-1:0] fen_vec;
  logic [MAX_SLOTS-1:0] een_vec;
  logic [MAX_SLOTS-1:0] occ_vec;
  logic [MAX_SLOTS-1:0] vac_vec;
  logic [15:0]          line_mask [MAX_LINES];
  logic [DATA_W-1:0]    status_w;
  logic [DATA_W-1:0]    rd_mux;

  assign sel         = decode_addr(reg_addr, NUM_SLOTS, NUM_LINES);
  assign wr_go       = reg_req & reg_we;
  assign rd_go       = reg_req & ~reg_we;
  assign unmapped_wr = wr_go && (sel.kind == K_NONE || sel.kind == K_STATUS || sel.kind == K_CAPS);

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    if (i < NUM_SLOTS) begin : g_on
      logic wr_d, wr_f, wr_e;
      assign wr_d = wr_go && sel.kind == K_SLOT_DATA && sel.idx == 4'(i);
      assign wr_f = wr_go && sel.kind == K_SLOT_FEN  && sel.idx == 4'(i);
      assign wr_e = wr_go && sel.kind == K_SLOT_EEN  && sel.idx == 4'(i);
      mbx_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_i  (wr_d),
        .wr_fen_i   (wr_f),
        .wr_een_i   (wr_e),
        .wdata_i    (reg_wdata),
        .hw_clear_i (slot_clear[i]),
        .word_o     (slot_word[i]),
        .full_en_o  (fen_vec[i]),
        .empty_en_o (een_vec[i]),
        .occupied_o (occ_vec[i]),
        .vacant_o   (vac_vec[i])
      );
    end else begin : g_off
      assign slot_word[i] = '0;
      assign fen_vec[i]   = 1'b0;
      assign een_vec[i]   = 1'b0;
      assign occ_vec[i]   = 1'b0;
      assign vac_vec[i]   = 1'b0;
    end
  end

  assign status_w = pack_status(vac_vec, occ_vec);

  for (genvar k = 0; k < MAX_LINES; k++) begin : g_line
    if (k < NUM_LINES) begin : g_on
      logic wr_m;
      assign wr_m = wr_go && sel.kind == K_LINE_MASK && sel.idx == 4'(k);
      mbx_line #(.VALID(VALID16)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_m),
        .wdata_i  (reg_wdata[15:0]),
        .status_i (status_w[15:0]),
        .mask_o   (line_mask[k]),
        .irq_o    (irq_line[k])
      );
    end else begin : g_off
      assign line_mask[k] = '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      K_SLOT_DATA: rd_mux = slot_word[sel.idx[2:0]];
      K_SLOT_FEN:  rd_mux = {31'b0, fen_vec[sel.idx[2:0]]};
      K_SLOT_EEN:  rd_mux = {31'b0, een_vec[sel.idx[2:0]]};
      K_LINE_MASK: rd_mux = {16'b0, line_mask[sel.idx]};
      K_STATUS:    rd_mux = status_w;
      K_CAPS:      rd_mux = CAPS_WORD;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ready <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ready <= reg_req;
      reg_rdata <= rd_go ? rd_mux : '0;
    end
  end

  // R9: acknowledge follows a request by exactly one cycle
  p_ready_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_ready);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !reg_ready);

  // R9: writes return zero data
  p_write_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> reg_rdata == '0);

  // R8: writes to unmapped or read-only space leave the status untouched
  p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_wr && slot_clear == '0) |=> $stable(status_w));

  // R5: a slot never reports vacant and occupied together
  p_status_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[15:8] & status_w[7:0]) == 8'h00);

endmodule

// File: tb/mbx_bank_test.sv
module mbx_bank_test;
  localparam int PERIOD = 10;
  localparam int NS = 6;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_req = 1'b0;
  logic          reg_we = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_ready;
  logic [NS-1:0] slot_clear = '0;
  logic [NL-1:0] irq_line;

  always #(PERIOD/2) clk = ~clk;

  mbx_bank #(.NUM_SLOTS(NS), .NUM_LINES(NL), .SEM_SHARED_CNT(2),
             .SEM_ARB_CNT(5), .DOORBELL_CNT(9)) uut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .slot_clear(slot_clear), .irq_line(irq_line)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference state
  bit [31:0] md [8];
  bit        mf [8];
  bit        me [8];
  bit [15:0] mm [16];

  function automatic bit [15:0] valid16();
    int v = (1 << NS) - 1;
    return 16'(v | (v << 8));
  endfunction

  function automatic bit [31:0] m_status();
    bit [31:0] s = 0;
    for (int n = 0; n < NS; n++) begin
      if (md[n][31]) begin
        if (mf[n]) s[8+n] = 1'b1;
      end else if (me[n]) begin
        s[n] = 1'b1;
      end
    end
    return s;
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a < 128 && (a / 16) < NS) begin
      case (a % 16)
        0: return md[a/16];
        4: return {31'b0, mf[a/16]};
        8: return {31'b0, me[a/16]};
        default: return 0;
      endcase
    end
    if (a >= 512 && a < 576 && a % 4 == 0 && (a - 512) / 4 < NL) return {16'b0, mm[(a-512)/4]};
    if (a == 768) return m_status();
    if (a == 784) return 32'h00039526;
    return 0;
  endfunction

  task automatic m_update(bit req, bit we, int a, bit [31:0] w, bit [NS-1:0] clr);
    for (int n = 0; n < NS; n++) if (clr[n]) md[n] = 0;
    if (req && we) begin
      if (a < 128 && (a / 16) < NS) begin
        case (a % 16)
          0: md[a/16] = w;
          4: mf[a/16] = w[0];
          8: me[a/16] = w[0];
          default: ;
        endcase
      end else if (a >= 512 && a < 576 && a % 4 == 0 && (a - 512) / 4 < NL) begin
        mm[(a-512)/4] = w[15:0] & valid16();
      end
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_lines();
    bit [31:0] st = m_status();
    for (int k = 0; k < NL; k++)
      check("R6 irq_line", {31'b0, irq_line[k]}, {31'b0, |(st[15:0] & mm[k])});
  endtask

  task automatic step(bit req, bit we, int a, bit [31:0] w, bit [NS-1:0] clr, string tag);
    bit [31:0] er;
    reg_req = req; reg_we = we; reg_addr = 12'(a); reg_wdata = w; slot_clear = clr;
    er = (req && !we) ? m_read(a) : 0;
    @(posedge clk);
    m_update(req, we, a, w, clr);
    #1;
    reg_req = 0; reg_we = 0; slot_clear = '0;
    check("R9 ready", {31'b0, reg_ready}, {31'b0, req});
    check(tag, reg_rdata, er);
    cmp_lines();
  endtask

  task automatic wr(int a, bit [31:0] w, string tag);
    step(1, 1, a, w, '0, tag);
  endtask

  task automatic rd(int a, string tag);
    step(1, 0, a, 0, '0, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", {31'b0, reg_ready}, 0);
    check("R1 rdata in reset", reg_rdata, 0);
    check("R1 irq in reset", {29'b0, irq_line}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < NS; n++) begin
      rd(n * 16, "R1 slot word");
      rd(n * 16 + 4, "R1 occupied enable");
      rd(n * 16 + 8, "R1 vacant enable");
    end
    for (int k = 0; k < NL; k++) rd(512 + 4 * k, "R1 line mask");
    rd(768, "R1 status");

    // R7
    rd(784, "R7 caps");
    check("R7 caps literal", reg_rdata, 32'h00039526);

    // R10
    wr(4, 32'hFFFF_FFFE, "R10 write");
    rd(4, "R10 bit0 only");
    check("R10 literal", reg_rdata, 0);
    wr(4, 32'h0000_0003, "R10 write");
    rd(4, "R10 readback");
    check("R10 literal one", reg_rdata, 32'h1);

    // R2
    wr(0, 32'h8000_1234, "R2 write");
    rd(0, "R2 readback");
    check("R2 literal", reg_rdata, 32'h8000_1234);
    wr(16 * 5, 32'h7FFF_FFFF, "R2 write no flag");
    rd(16 * 5, "R2 payload only");

    // R5
    wr(16 + 8, 1, "R5 vacant enable");
    rd(768, "R5 status");
    check("R5 literal", reg_rdata, 32'h0000_0102);
    rd(768, "R9 status reread stable");

    // R6
    wr(512, 32'h0000_0100, "R6 mask0");
    check("R6 line0 high", {31'b0, irq_line[0]}, 1);
    wr(516, 32'hFFFF_FFFF, "R6 mask1");
    rd(516, "R6 mask1 readback");
    check("R6 mask literal", reg_rdata, 32'h0000_3F3F);
    wr(520, 32'h0000_0002, "R6 mask2");

    // R3
    wr(0, 0, "R3 consumer release");
    rd(0, "R3 slot empty");
    check("R3 line0 low", {31'b0, irq_line[0]}, 0);

    // R4
    wr(32, 32'h8000_00AA, "R4 load");
    wr(32 + 4, 1, "R4 enable");
    step(1, 0, 32, 0, 6'b000100, "R9 read during clear returns old");
    check("R9 old value", reg_rdata, 32'h8000_00AA);
    rd(32, "R4 cleared");
    check("R4 cleared literal", reg_rdata, 0);
    wr(48, 32'h8000_0001, "R4 load3");
    step(1, 1, 48, 32'h8000_0077, 6'b001000, "R4 collision write");
    rd(48, "R4 write wins");
    check("R4 write wins literal", reg_rdata, 32'h8000_0077);

    // R8
    wr(96, 32'h8000_0001, "R8 slot6 write");
    rd(96, "R8 slot6 read");
    wr(12, 32'hFFFF_FFFF, "R8 offset C");
    rd(12, "R8 offset C read");
    wr(512 + 12, 32'hFFFF, "R8 line3");
    rd(512 + 12, "R8 line3 read");
    wr(768, 32'hFFFF_FFFF, "R8 status write");
    rd(768, "R8 status unchanged");
    wr(784, 0, "R8 caps write");
    rd(784, "R8 caps unchanged");
    wr(1024, 32'h1234_5678, "R8 far write");
    rd(1024, "R8 far read");
    check("R8 far literal", reg_rdata, 0);

    // Mixed random stream
    for (int i = 0; i < 600; i++) begin
      int pick = int'($urandom % 32);
      int a;
      bit [31:0] w = $urandom;
      bit [NS-1:0] c = ($urandom % 4 == 0) ? NS'($urandom) : '0;
      if (pick < 24) a = (pick / 3) * 16 + (pick % 3) * 4;
      else if (pick < 28) a = 512 + 4 * (pick - 24);
      else if (pick == 28) a = 768;
      else if (pick == 29) a = 784;
      else if (pick == 30) a = 12;
      else a = 1024;
      if (pick % 3 != 0) w[0] = w[1];
      step($urandom % 8 != 0, $urandom % 2 == 0, a, w, c, "R5 random mix");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule